// File: doc/BRIEF.md
# Coprocessor Save-Register Responder

This block sits on the coprocessor side of a context-save exchange. The host starts a save by reading the save status register. The block answers with a 16-bit format code that describes what the coprocessor can hand over at that moment.

- If the execution unit is still changing internal state, the reply is a "not ready" code. The block then raises a suspend request, so that the unit either parks or finishes its operation while the host retries.
- Once the unit is quiet and still holds a parked operation, the reply is a frame format word. Its high byte is a fixed identifier and its low byte is the byte count of the state that follows.
- Successive reads of the operand register then return the state words one at a time, in index order, from the coprocessor's internal state storage. The storage is read through an address output and a same-cycle data input.
- When no operation is held, the reply is a null code with no state behind it.

The host sees every reply one cycle after its read strobe.

Top module: `cp_save_responder`

## Requirements
- R1: After reset, `rd_data` is 0x0000, `suspend_req` is low, `st_addr` is 0, and no frame is pending.
- R2: A save read (`rd_stb`=1, `rd_sel`=0) while `exec_busy`=1 gives `rd_data`=0x0100 ("not ready") on the next cycle and raises `suspend_req` in that same cycle.
- R3: `suspend_req` stays high until a save read is answered with a code other than "not ready". That read clears it in the cycle its reply appears.
- R4: A save read with `exec_busy`=0 and `exec_held`=0 gives the null code 0x0000 on the next cycle and leaves no frame pending.
- R5: A save read with `exec_busy`=0 and `exec_held`=1 gives the frame word {FMT_ID, 2*STATE_WORDS} on the next cycle: identifier in bits 15:8, byte count in bits 7:0. With the defaults this is 0x3C0C.
- R6: After a frame word, the k-th operand read (`rd_stb`=1, `rd_sel`=1) returns the storage word at index k, for k = 0 to STATE_WORDS-1. `st_addr` shows that index when the read strobe is sampled.
- R7: After the last state word is read, the block is idle again: `st_addr` returns to 0 and further operand reads return 0x0000.
- R8: An operand read with no frame pending returns 0x0000 and leaves `st_addr` unchanged.
- R9: A save read during a frame readout restarts the exchange. The format word is returned again, and the next operand read returns state word 0.
- R10: Without a read strobe, `rd_data`, `st_addr` and `suspend_req` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb | input | 1 | Register read strobe, one cycle per read |
| rd_sel | input | 1 | Register select: 0 = save status register, 1 = operand register |
| exec_busy | input | 1 | Execution unit is still changing internal state |
| exec_held | input | 1 | An operation is parked and its state is retained |
| rd_data | output | 16 | Read reply, valid from the cycle after the strobe |
| suspend_req | output | 1 | Asks the execution unit to suspend or finish its operation |
| st_addr | output | IW | Word index into internal state storage |
| st_rdata | input | 16 | Storage word at `st_addr`, same cycle |

## Verification
A wrong readout index shows up at the first operand read after a frame word. That read returns a word other than storage word 0, and the wrong word persists through the rest of the frame. A pending flag that is lost or left set shows up one read later: a nonzero word appears where 0x0000 is due, or a zero word appears where state is due. A stuck suspend request shows on `suspend_req` in the cycle after the save read that should have cleared it.

// File: rtl/cp_save_responder.sv
module cp_save_responder #(
  parameter int STATE_WORDS = 6,
  parameter logic [7:0] FMT_ID = 8'h3C,
  parameter int IW = $clog2(STATE_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_stb,
  input  logic          rd_sel,
  input  logic          exec_busy,
  input  logic          exec_held,
  output logic [15:0]   rd_data,
  output logic          suspend_req,
  output logic [IW-1:0] st_addr,
  input  logic [15:0]   st_rdata
);

  localparam logic [15:0]   NOT_READY = 16'h0100;
  localparam logic [15:0]   NULL_FMT  = 16'h0000;
  localparam logic [7:0]    LEN_BYTES = 8'(2 * STATE_WORDS);
  localparam logic [15:0]   FRAME_FMT = {FMT_ID, LEN_BYTES};
  localparam logic [IW-1:0] LAST_IDX  = IW'(STATE_WORDS - 1);

  logic          dumping;
  logic [IW-1:0] idx;

  wire save_rd = rd_stb & ~rd_sel;
  wire op_rd   = rd_stb &  rd_sel;

  assign st_addr = idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data     <= NULL_FMT;
      suspend_req <= 1'b0;
      dumping     <= 1'b0;
      idx         <= '0;
    end else if (save_rd) begin
      idx <= '0;
      if (exec_busy) begin
        rd_data     <= NOT_READY;
        suspend_req <= 1'b1;
        dumping     <= 1'b0;
      end else if (exec_held) begin
        rd_data     <= FRAME_FMT;
        suspend_req <= 1'b0;
        dumping     <= 1'b1;
      end else begin
        rd_data     <= NULL_FMT;
        suspend_req <= 1'b0;
        dumping     <= 1'b0;
      end
    end else if (op_rd) begin
      if (dumping) begin
        rd_data <= st_rdata;
        if (idx == LAST_IDX) begin
          idx     <= '0;
          dumping <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
        end
      end else begin
        rd_data <= NULL_FMT;
      end
    end
  end

  assert_notready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    save_rd && exec_busy |=> rd_data == NOT_READY && suspend_req);

  assert_suspend_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(suspend_req) |-> $past(save_rd) && rd_data != NOT_READY);

  assert_null_R4: assert property (@(posedge clk) disable iff (!rst_n)
    save_rd && !exec_busy && !exec_held |=> rd_data == NULL_FMT);

  assert_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    save_rd && !exec_busy && exec_held |=> rd_data == FRAME_FMT && st_addr == '0);

  assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st_addr <= LAST_IDX);

  assert_stray_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_rd && !dumping |=> rd_data == NULL_FMT && $stable(st_addr));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data) && $stable(st_addr) && $stable(suspend_req));

endmodule

// File: tb/sim_cp_save_responder.sv
module sim_cp_save_responder;
  localparam int N = 6;
  localparam int IW = $clog2(N);
  localparam logic [15:0] FRAME = 16'h3C0C;

  logic clk = 0, rst_n = 0, rd_stb = 0, rd_sel = 0, exec_busy = 0, exec_held = 0;
  logic [15:0] rd_data, st_rdata;
  logic suspend_req;
  logic [IW-1:0] st_addr;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign st_rdata = 16'hC000 + 16'(st_addr) * 16'h0111;

  cp_save_responder #(.STATE_WORDS(N), .FMT_ID(8'h3C)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_sel(rd_sel),
    .exec_busy(exec_busy), .exec_held(exec_held), .rd_data(rd_data),
    .suspend_req(suspend_req), .st_addr(st_addr), .st_rdata(st_rdata));

  function automatic logic [15:0] word_at(int k);
    return 16'hC000 + 16'(k) * 16'h0111;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic sel);
    @(negedge clk);
    rd_stb = 1; rd_sel = sel;
    @(negedge clk);
    rd_stb = 0;
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 data", rd_data, 0);
    chk("R1 suspend", suspend_req, 0);
    chk("R1 addr", st_addr, 0);
    rd(1);
    chk("R1 no frame", rd_data, 0);
  endtask

  task automatic t_null();
    exec_busy = 0; exec_held = 0;
    rd(0);
    chk("R4 null", rd_data, 16'h0000);
    rd(1);
    chk("R4 no state", rd_data, 0);
  endtask

  task automatic t_notready();
    exec_busy = 1; exec_held = 0;
    rd(0);
    chk("R2 code", rd_data, 16'h0100);
    chk("R2 suspend", suspend_req, 1);
    repeat (3) @(negedge clk);
    chk("R3 held high", suspend_req, 1);
    chk("R10 data hold", rd_data, 16'h0100);
    rd(0);
    chk("R3 retry still busy", suspend_req, 1);
    exec_busy = 0; exec_held = 1;
    rd(0);
    chk("R5 frame", rd_data, FRAME);
    chk("R3 cleared", suspend_req, 0);
  endtask

  task automatic t_dump();
    for (int k = 0; k < N; k++) begin
      chk("R6 addr", st_addr, k);
      rd(1);
      chk("R6 word", rd_data, word_at(k));
    end
    chk("R7 addr back", st_addr, 0);
    rd(1);
    chk("R7 idle", rd_data, 0);
    chk("R8 addr unchanged", st_addr, 0);
  endtask

  task automatic t_restart();
    exec_busy = 0; exec_held = 1;
    rd(0);
    chk("R5 frame again", rd_data, FRAME);
    rd(1); rd(1); rd(1);
    chk("R9 mid word", rd_data, word_at(2));
    rd(0);
    chk("R9 format again", rd_data, FRAME);
    chk("R9 addr reset", st_addr, 0);
    rd(1);
    chk("R9 word0", rd_data, word_at(0));
    repeat (4) @(negedge clk);
    chk("R10 addr hold", st_addr, 1);
    chk("R10 data hold2", rd_data, word_at(0));
    exec_held = 0;
    rd(0);
    chk("R4 null abort", rd_data, 0);
    rd(1);
    chk("R8 after null", rd_data, 0);
    chk("R8 addr", st_addr, 0);
  endtask

  initial begin
    t_reset();
    t_null();
    t_notready();
    t_dump();
    t_restart();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule